// File: doc/BRIEF.md
# Ratio-Guarded Power-of-Two Clock Enable Bank

This block turns one parent clock into six clock-enable pulse streams, one each for the peripheral, LCD, processor, DSP, DSP address-translation and bus domains. A single 16-bit control word sets how often each stream pulses. Each domain owns a 2-bit exponent `e`, and its enable goes high once every `2^e` parent cycles, which gives a divide ratio of 1, 2, 4 or 8.

Any value written to the control word is repaired by hardware before it is stored. The repair enforces fixed ratio rules between the domains, so an illegal combination of dividers can never reach the pulse generators. The rules are applied in a fixed order. First the DSP address-translation exponent is clamped into a window set by the DSP exponent. Next the bus exponent is raised so the bus is no faster than the processor or the translation clock. Last, the LCD and peripheral exponents are raised so those domains are no faster than the bus. There is no maximum-frequency check.

A domain that receives a new exponent finishes its current divide period before the new exponent takes effect. Because of this, no pulse is ever emitted early.

Top module: `clkdiv_bank`

## Requirements
- R1: Field positions in the control word are: peripheral [1:0], LCD [3:2], processor [5:4], DSP [7:6], DSP translation [9:8], bus [11:10]. Domain d drives `tick[d]` with index 0=peripheral, 1=LCD, 2=processor, 3=DSP, 4=translation, 5=bus. In steady state `tick[d]` is high for one cycle in every 2^field cycles.
- R2: The stored translation exponent is raised to at least the DSP exponent and then limited to at most the DSP exponent plus one.
- R3: After R2, the stored bus exponent is raised to at least the processor exponent and then to at least the corrected translation exponent.
- R4: After R3, the stored LCD and peripheral exponents are each raised to at least the corrected bus exponent. A written value already larger is kept.
- R5: `rd_data` shows the corrected word in the cycle after a write is sampled. The raw written value is never shown. Fields the rules do not touch keep their written values.
- R6: Bits [15:12] of a write are stored and read back unchanged.
- R7: A new exponent takes effect only when the domain reaches the terminal count of its current period. Every interval between two consecutive pulses equals either the old or the new divide ratio, and after the switch the new ratio holds.
- R8: Reset clears the whole control word to zero, so every `tick` bit is high on every cycle.
- R9: While `wr_en` is low, `rd_data` does not change, whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Raw control word to be repaired and stored |
| rd_data | output | 16 | Stored, corrected control word |
| tick | output | 6 | One clock-enable pulse per domain |

## Verification
Two functions can coincide in a single cycle: a register write and a domain's terminal count. In that case the pulse generator reloads from the old stored word while the register captures the new one. The bench provokes this in two ways:
- It writes while fast domains pulse on every cycle.
- It writes at fixed offsets inside slow periods.

The result is judged by measuring every pulse-to-pulse interval around the write. Each interval must be either the old or the new ratio, and the last interval must be the new ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int NDOM  = 6;
    localparam int D_PER = 0;
    localparam int D_LCD = 1;
    localparam int D_CPU = 2;
    localparam int D_DSP = 3;
    localparam int D_MMU = 4;
    localparam int D_BUS = 5;
endpackage

// File: rtl/ratio_repair.sv
module ratio_repair
    import clkdiv_pkg::*;
#(
    parameter int EXPW = 2
) (
    input  logic [NDOM*EXPW-1:0] raw_i,
    output logic [NDOM*EXPW-1:0] fix_o
);
    localparam logic [EXPW:0] ONE = 1;

    logic [EXPW:0] f [NDOM];

    always_comb begin
        for (int d = 0; d < NDOM; d++) begin
            f[d] = {1'b0, raw_i[d*EXPW +: EXPW]};
        end
        // step 1: translation clock within [dsp, dsp+1]
        if (f[D_MMU] < f[D_DSP]) f[D_MMU] = f[D_DSP];
        if (f[D_MMU] > f[D_DSP] + ONE) f[D_MMU] = f[D_DSP] + ONE;
        // step 2: bus no faster than processor or translation clock
        if (f[D_BUS] < f[D_CPU]) f[D_BUS] = f[D_CPU];
        if (f[D_BUS] < f[D_MMU]) f[D_BUS] = f[D_MMU];
        // step 3: LCD and peripheral no faster than bus
        if (f[D_LCD] < f[D_BUS]) f[D_LCD] = f[D_BUS];
        if (f[D_PER] < f[D_BUS]) f[D_PER] = f[D_BUS];
        for (int d = 0; d < NDOM; d++) begin
            fix_o[d*EXPW +: EXPW] = f[d][EXPW-1:0];
        end
    end
endmodule

// File: rtl/div_tick.sv
module div_tick #(
    parameter int EXPW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EXPW-1:0] exp_i,
    output logic            tick_o
);
    localparam int CW = (1 << EXPW) - 1;

    typedef struct packed {
        logic [CW-1:0]   cnt;
        logic [EXPW-1:0] act;
    } st_t;

    st_t           s_d, s_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim    = {CW{1'b1}} >> (CW - int'(s_q.act));
        tick_o = (s_q.cnt == lim);
        s_d    = s_q;
        if (tick_o) begin
            s_d.cnt = '0;
            s_d.act = exp_i;   // new ratio only at period boundary
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int EXPW   = 2,
    parameter int PASS_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [NDOM*EXPW+PASS_W-1:0] wr_data,
    output logic [NDOM*EXPW+PASS_W-1:0] rd_data,
    output logic [NDOM-1:0]             tick
);
    localparam int FW = NDOM * EXPW;
    localparam int W  = FW + PASS_W;

    typedef struct packed {
        logic [W-1:0] ctl;
    } st_t;

    st_t            s_d, s_q;
    logic [FW-1:0]  fixed;

    ratio_repair #(.EXPW(EXPW)) u_fix (
        .raw_i (wr_data[FW-1:0]),
        .fix_o (fixed)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.ctl = {wr_data[W-1:FW], fixed};
        rd_data = s_q.ctl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        div_tick #(.EXPW(EXPW)) u_tick (
            .clk    (clk),
            .rst_n  (rst_n),
            .exp_i  (s_q.ctl[d*EXPW +: EXPW]),
            .tick_o (tick[d])
        );
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
    import clkdiv_pkg::*;
#(
    parameter int EXPW   = 2,
    parameter int PASS_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [NDOM*EXPW+PASS_W-1:0] wr_data,
    input logic [NDOM*EXPW+PASS_W-1:0] rd_data,
    input logic [NDOM-1:0]             tick
);
    localparam int FW     = NDOM * EXPW;
    localparam int W      = FW + PASS_W;
    localparam int CW     = (1 << EXPW) - 1;
    localparam int MAXDIV = 1 << CW;

    logic [EXPW:0] e [NDOM];
    always_comb begin
        for (int d = 0; d < NDOM; d++) e[d] = {1'b0, rd_data[d*EXPW +: EXPW]};
    end

    a_r2_mmu_window: assert property (@(posedge clk) disable iff (!rst_n)
        (e[D_MMU] >= e[D_DSP]) && (e[D_MMU] <= e[D_DSP] + 1'b1));

    a_r3_bus_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (e[D_BUS] >= e[D_CPU]) && (e[D_BUS] >= e[D_MMU]));

    a_r4_slow_periph: assert property (@(posedge clk) disable iff (!rst_n)
        (e[D_LCD] >= e[D_BUS]) && (e[D_PER] >= e[D_BUS]));

    a_r6_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[W-1:FW] == $past(wr_data[W-1:FW]));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    for (genvar d = 0; d < NDOM; d++) begin : g_gap
        logic [CW:0] gap;
        always_ff @(posedge clk) begin
            if (!rst_n)       gap <= '0;
            else if (tick[d]) gap <= '0;
            else              gap <= gap + 1'b1;
        end
        // R7: no period is ever longer than the largest ratio
        a_r7_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
            gap < (CW+1)'(MAXDIV));
    end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.EXPW(EXPW), .PASS_W(PASS_W)) u_chk (.*);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [5:0]  tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    clkdiv_bank i_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .tick(tick)
    );

    function automatic int fld(input logic [15:0] w, input int d);
        return int'((w >> (2*d)) & 16'h3);
    endfunction

    function automatic logic [15:0] fix(input logic [15:0] w);
        int f [6];
        logic [15:0] r;
        for (int d = 0; d < 6; d++) f[d] = fld(w, d);
        if (f[4] < f[3]) f[4] = f[3];
        if (f[4] > f[3] + 1) f[4] = f[3] + 1;
        if (f[5] < f[2]) f[5] = f[2];
        if (f[5] < f[4]) f[5] = f[4];
        if (f[1] < f[5]) f[1] = f[5];
        if (f[0] < f[5]) f[0] = f[5];
        r = {w[15:12], 12'h0};
        for (int d = 0; d < 6; d++) r = r | (16'(f[d]) << (2*d));
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R7: intervals around a write must be the old or the new ratio
    task automatic switch_check(input logic [15:0] a, input logic [15:0] b, input int pre);
        int cnt [6];
        bit seen [6];
        int last [6];
        logic [15:0] fa, fb;
        fa = fix(a); fb = fix(b);
        write(a);
        repeat (20) @(negedge clk);
        for (int d = 0; d < 6; d++) begin cnt[d] = 0; seen[d] = 0; last[d] = 0; end
        for (int k = 0; k < 80; k++) begin
            if (k == pre) begin wr_en = 1'b1; wr_data = b; end
            else wr_en = 1'b0;
            @(negedge clk);
            for (int d = 0; d < 6; d++) begin
                if (seen[d]) cnt[d]++;
                if (tick[d]) begin
                    if (seen[d])
                        check(cnt[d] == (1 << fld(fa, d)) || cnt[d] == (1 << fld(fb, d)),
                              "R7 interval", cnt[d], 1 << fld(fb, d));
                    if (seen[d]) last[d] = cnt[d];
                    seen[d] = 1; cnt[d] = 0;
                end
            end
        end
        wr_en = 1'b0;
        for (int d = 0; d < 6; d++)
            check(last[d] == (1 << fld(fb, d)), "R7 final ratio", last[d], 1 << fld(fb, d));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, hold;
        int n [6];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(rd_data == 16'h0, "R8 reset word", rd_data, 0);
        for (int k = 0; k < 3; k++) begin
            check(tick == 6'h3f, "R8 ticks every cycle", tick, 6'h3f);
            @(negedge clk);
        end

        // R2 R3 R4 R5 R6: exhaustive sweep of all field combinations
        for (int i = 0; i < 4096; i++) begin
            v = {4'(i * 5 + 3), 12'(i)};
            write(v);
            check(rd_data == fix(v), "R2/R3/R4 R5 R6 corrected word", rd_data, fix(v));
        end

        // R9: no write, data wiggles, word holds
        write(16'h9a5e);
        hold = rd_data;
        for (int k = 0; k < 6; k++) begin
            wr_data = 16'(k * 16'h1357);
            @(negedge clk);
            check(rd_data == hold, "R9 hold", rd_data, hold);
        end

        // R1: steady-state pulse rate per domain
        for (int j = 0; j < 64; j++) begin
            v = 16'((j * 1237 + 5) & 12'hfff);
            write(v);
            repeat (20) @(negedge clk);
            for (int d = 0; d < 6; d++) n[d] = 0;
            for (int k = 0; k < 64; k++) begin
                for (int d = 0; d < 6; d++) if (tick[d]) n[d]++;
                @(negedge clk);
            end
            for (int d = 0; d < 6; d++)
                check(n[d] == (64 >> fld(fix(v), d)), "R1 pulse rate", n[d], 64 >> fld(fix(v), d));
        end

        // R7: switches at several offsets into a period
        switch_check(16'h0000, 16'h0fff, 10);
        switch_check(16'h0fff, 16'h0000, 11);
        switch_check(16'h0fff, 16'h0000, 14);
        switch_check(16'h0550, 16'h0aa5, 12);
        switch_check(16'h0a85, 16'h0140, 13);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule